// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller takes eight interrupt request lines and records a rising edge on each of them as a pending request. It compares the unmasked pending requests with the lines whose handlers are already running, and it raises one interrupt output toward the processor only when a pending request outranks all of those handlers. Line 0 has the highest priority and line 7 the lowest.

The processor answers the interrupt with a one-cycle acknowledge pulse. On the next cycle the controller returns an 8-bit vector: a programmable base in the upper five bits and the winning line number in the lower three. A flag marks that cycle as the one carrying a valid vector. The acknowledge also moves the winning line from pending to in-service. An end-of-interrupt pulse retires the highest-priority handler that is in service, so nested handlers are retired in order. A small write port sets the vector base and the per-line mask.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `int_out`, `vec_valid` and `vec_out` are 0, the vector base is 0, no line is pending or in service, and the mask is all ones, so every line is blocked.
- R2: A 0-to-1 transition on `irq_in[i]` makes line i pending. The request stays pending after the line falls. A line held high gives exactly one request.
- R3: A pulse on `reg_we` with `reg_sel`=0 stores `reg_wdata[7:3]` as the vector base and ignores bits 2:0. With `reg_sel`=1 it stores `reg_wdata` as the mask. Mask bit i = 1 keeps pending line i out of the selection, but the request stays pending and is served once the bit is cleared.
- R4: Among the unmasked pending lines, the lowest index wins. The vector is {base[7:3], index[2:0]}.
- R5: An `ack` pulse while `int_out` is 1 makes `vec_valid` 1 for exactly the next cycle, with the vector on `vec_out`. It also clears the winner's pending bit and sets its in-service bit. An `ack` while `int_out` is 0 produces no `vec_valid`, leaves `vec_out` unchanged and leaves all state unchanged.
- R6: `int_out` is 1 exactly when some unmasked pending line has a lower index than every in-service line. If no line is in service, any unmasked pending line is enough.
- R7: While a handler is in service, a new request from a higher-priority line raises `int_out`. A request from a lower-priority line does not raise it.
- R8: An `eoi` pulse clears only the lowest-index in-service bit. Any pending line that this uncovers is then signalled on `int_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines, captured on their rising edges |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the vector base, 1 selects the mask |
| reg_wdata | input | 8 | Register write data |
| ack | input | 1 | Interrupt acknowledge pulse from the processor |
| eoi | input | 1 | End-of-interrupt pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the acknowledged line |
| vec_valid | output | 1 | High for the one cycle that follows an accepted acknowledge |

## Verification
The bench first raises a line while the reset mask still blocks it, then clears the mask and expects the held request to appear. A design that dropped masked requests would stay silent at that point. Nested handling is tested at three levels: a lower line arrives during a handler and must wait, a higher line arrives and must preempt, and end-of-interrupt pulses must retire handlers from the highest priority down. A design that cleared the wrong in-service bit would signal too early or lose a request. The bench also sends an acknowledge with nothing pending and holds a line high across its own service, to catch designs that emit a phantom vector or re-request on a level instead of an edge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_first_set.sv
// Finds the lowest set bit of a vector: index, found flag and one-hot form.
module irq_first_set #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign found = |vec;

  generate
    for (genvar g = 0; g < N; g++) begin : g_oh
      assign onehot[g] = found && (idx == IW'(g));
    end
  endgenerate
endmodule

// File: rtl/irq_edge_latch.sv
// Rising-edge capture into sticky pending bits, with per-bit clear.
module irq_edge_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] irq_d;
  logic [N-1:0] pend_next;
  logic [N-1:0] rise;

  always_comb begin
    rise      = irq_in & ~irq_d;
    pend_next = (pend & ~clr) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_d <= '0;
      pend  <= '0;
    end else begin
      irq_d <= irq_in;
      pend  <= pend_next;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_we,
  input  logic               reg_sel,
  input  logic [VEC_W-1:0]   reg_wdata,
  input  logic               ack,
  input  logic               eoi,
  output logic               int_out,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid
);
  import irq_prio_pkg::*;

  localparam int IDX_W  = $clog2(N_LINES);
  localparam int BASE_W = VEC_W - IDX_W;

  logic [BASE_W-1:0]  base_q, base_next;
  logic [N_LINES-1:0] mask_q, mask_next;
  logic [N_LINES-1:0] isr_q, isr_next;
  logic [VEC_W-1:0]   vec_next;
  logic               base_en, mask_en, take;

  logic [N_LINES-1:0] pend, live, pick_oh, top_oh, clr_pend;
  logic               pick_found, top_found;
  logic [IDX_W-1:0]   pick_idx, top_idx;

  irq_edge_latch #(.N(N_LINES)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (irq_in),
    .clr    (clr_pend),
    .pend   (pend)
  );

  assign live = pend & ~mask_q;

  irq_first_set #(.N(N_LINES), .IW(IDX_W)) u_pick (
    .vec    (live),
    .found  (pick_found),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  irq_first_set #(.N(N_LINES), .IW(IDX_W)) u_top (
    .vec    (isr_q),
    .found  (top_found),
    .idx    (top_idx),
    .onehot (top_oh)
  );

  always_comb begin
    int_out   = pick_found && (!top_found || (pick_idx < top_idx));
    take      = ack && int_out;
    clr_pend  = take ? pick_oh : '0;
    isr_next  = (isr_q & ~(eoi ? top_oh : '0)) | clr_pend;
    vec_next  = {base_q, pick_idx};
    base_en   = reg_we && (reg_sel == SEL_BASE);
    mask_en   = reg_we && (reg_sel == SEL_MASK);
    base_next = reg_wdata[VEC_W-1:IDX_W];
    mask_next = reg_wdata[N_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      mask_q    <= '1;
      isr_q     <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      if (base_en) base_q <= base_next;
      if (mask_en) mask_q <= mask_next;
      if (take)    vec_out <= vec_next;
      isr_q     <= isr_next;
      vec_valid <= take;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8,
  parameter int BASE_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack,
  input logic               eoi,
  input logic               int_out,
  input logic               vec_valid,
  input logic [VEC_W-1:0]   vec_out,
  input logic [BASE_W-1:0]  base_q,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] isr_q
);
  AST_ACK_GIVES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out) |=> vec_valid); // R5
  AST_NO_PHANTOM_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && int_out) |=> !vec_valid); // R5
  AST_VECTOR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_out[VEC_W-1:VEC_W-BASE_W] == base_q)); // R4
  AST_ISR_GROWS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !eoi) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1)); // R5
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && (isr_q != '0)) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1)); // R8
  AST_QUIET_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !int_out); // R3
endmodule

bind irq_prio_ctrl irq_prio_chk #(
  .N_LINES (N_LINES),
  .VEC_W   (VEC_W),
  .BASE_W  (BASE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack       (ack),
  .eoi       (eoi),
  .int_out   (int_out),
  .vec_valid (vec_valid),
  .vec_out   (vec_out),
  .base_q    (base_q),
  .mask_q    (mask_q),
  .isr_q     (isr_q)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       reg_we, reg_sel, ack, eoi;
  logic [7:0] reg_wdata;
  logic       int_out, vec_valid;
  logic [7:0] vec_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ack(ack), .eoi(eoi),
    .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    step();
    eoi = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    irq_in = v;
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    check("R1 int_out", {7'd0, int_out}, 8'd0);
    check("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
    check("R1 vec_out", vec_out, 8'h00);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_mask_and_base();
    set_irq(8'h04);
    check("R1 masked at reset", {7'd0, int_out}, 8'd0);
    wr(1'b1, 8'h00);
    check("R3 held request served after unmask", {7'd0, int_out}, 8'd1);
    wr(1'b0, 8'h47);
    do_ack();
    check("R5 vec_valid", {7'd0, vec_valid}, 8'd1);
    check("R3 R4 vector low bits ignored", vec_out, 8'h42);
    check("R6 no int after take", {7'd0, int_out}, 8'd0);
    step();
    check("R5 vec_valid one cycle", {7'd0, vec_valid}, 8'd0);
    do_eoi();
    check("R2 held line gives one request", {7'd0, int_out}, 8'd0);
    set_irq(8'h00);
  endtask

  task automatic t_priority();
    set_irq(8'h48);
    check("R6 int raised", {7'd0, int_out}, 8'd1);
    do_ack();
    check("R4 line 3 wins over 6", vec_out, 8'h43);
    check("R6 lower pending waits", {7'd0, int_out}, 8'd0);
    do_eoi();
    check("R8 eoi uncovers line 6", {7'd0, int_out}, 8'd1);
    do_ack();
    check("R4 line 6 vector", vec_out, 8'h46);
    do_eoi();
    set_irq(8'h00);
  endtask

  task automatic t_preempt();
    set_irq(8'h20);
    do_ack();
    check("R5 line 5 vector", vec_out, 8'h45);
    set_irq(8'hA0);
    check("R7 lower line 7 no preempt", {7'd0, int_out}, 8'd0);
    set_irq(8'hA2);
    check("R7 higher line 1 preempts", {7'd0, int_out}, 8'd1);
    do_ack();
    check("R7 nested vector", vec_out, 8'h41);
    set_irq(8'hB2);
    check("R6 line 4 below line 1", {7'd0, int_out}, 8'd0);
    do_eoi();
    check("R8 eoi clears line 1 only", {7'd0, int_out}, 8'd1);
    do_ack();
    check("R4 line 4 vector", vec_out, 8'h44);
    do_eoi();
    check("R8 line 5 still in service", {7'd0, int_out}, 8'd0);
    do_eoi();
    check("R8 line 7 uncovered", {7'd0, int_out}, 8'd1);
    do_ack();
    check("R4 line 7 vector", vec_out, 8'h47);
    do_eoi();
    check("R6 nothing left", {7'd0, int_out}, 8'd0);
    set_irq(8'h00);
  endtask

  task automatic t_spurious_and_mask();
    do_ack();
    check("R5 no vector without int", {7'd0, vec_valid}, 8'd0);
    check("R5 vec_out unchanged", vec_out, 8'h47);
    wr(1'b1, 8'h01);
    set_irq(8'h01);
    check("R3 masked line silent", {7'd0, int_out}, 8'd0);
    do_ack();
    check("R5 ack on masked line ignored", {7'd0, vec_valid}, 8'd0);
    wr(1'b1, 8'h00);
    check("R3 pending survives ack while masked", {7'd0, int_out}, 8'd1);
    do_ack();
    check("R4 line 0 vector", vec_out, 8'h40);
    do_eoi();
    set_irq(8'h00);
  endtask

  task automatic t_short_pulse();
    set_irq(8'h04);
    set_irq(8'h00);
    check("R2 pulse latched", {7'd0, int_out}, 8'd1);
    do_ack();
    check("R2 pulse vector", vec_out, 8'h42);
    do_eoi();
    check("R2 no repeat", {7'd0, int_out}, 8'd0);
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; reg_we = 1'b0; reg_sel = 1'b0;
    reg_wdata = '0; ack = 1'b0; eoi = 1'b0;
    t_reset();
    t_mask_and_base();
    t_priority();
    t_preempt();
    t_spurious_and_mask();
    t_short_pulse();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule